// File: doc/BRIEF.md
# Dual-Bank Flash Write Status Generator

This block sits between the array read path and the data pins of a flash memory split into a small bank and a large bank. While an internal program or erase runs in one bank, a read that targets that bank must return a status word instead of array contents. The block overrides three bits of the word: bit 7 is the polling bit, bit 6 is the main toggle bit and bit 2 is the erase toggle bit. The other bits, and every read of the other bank, pass the array data through unchanged. The block also drives an active-low busy flag.

The command decoder reports an accepted operation with a one-cycle `op_start` pulse. It gives the operation's kind, its target address and the data being written. The program/erase engine reports completion with `op_done`. The decoder also forwards suspend and resume requests. Each read arrives as a one-cycle `rd_stb` with an address and the array word for that address. The result is registered and appears on `rd_data` from the cycle after the strobe. It holds until the next strobe.

A four-state machine drives the block. The states are IDLE, PROG, ERASE and SUSP. Its transitions are START_PROG (IDLE to PROG), START_ERASE (IDLE to ERASE), FINISH (PROG or ERASE to IDLE on `op_done`), SUSPEND (ERASE to SUSP) and RESUME (SUSP to ERASE). The two toggle bits each live in their own flop. A toggle bit flips only on a read strobe that the current state qualifies.

Top module: `flash_wstat`

## Requirements
- R1: After reset, `rd_data` is zero and `busy_n` is 1.
- R2: In IDLE, a strobed read places `arr_data` on `rd_data` in the cycle after the strobe. This also applies when `op_start` arrives in the same cycle as the read.
- R3: In PROG, a read of the busy bank returns the array word with bit 7 replaced by the complement of bit 7 of the programmed data and bit 6 replaced by the main toggle bit. Bit 2 keeps the array value.
- R4: In ERASE, a read of the busy bank returns bit 7 = 0, bit 6 = main toggle and bit 2 = erase toggle. Both toggle bits flip on each such read.
- R5: Both toggle bits are 0 for the first status read after an accepted start. The main toggle flips on each qualified busy-bank read in PROG or ERASE and on nothing else. Idle clock cycles do not change it.
- R6: A read whose address lies in the non-busy bank returns `arr_data` unchanged and flips neither toggle bit.
- R7: In SUSP, a read inside the suspended sector returns bit 7 = 1, bit 6 = 1 and bit 2 = erase toggle, which then flips. A read outside that sector returns array data. The sector is the top SECT_W address bits latched at start.
- R8: `busy_n` is 0 from the cycle after an accepted start until FINISH. It is 1 in SUSP and returns to 0 after RESUME.
- R9: After FINISH, reads return array data. A read strobed in the same cycle as `op_done` still returns the status word.
- R10: The top three address bits form a slice index from 0 to 7. With SMALL_AT_TOP = 0, the small bank is slices below SMALL_SLICES. With SMALL_AT_TOP = 1, the small bank is the top SMALL_SLICES slices.
- R11: `op_start` is ignored outside IDLE. `susp_req` is ignored outside ERASE. `resume_req` is ignored outside SUSP.
- R12: `rd_data` does not change in a cycle without a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_start | input | 1 | Operation accepted by the command decoder |
| op_erase | input | 1 | Kind of the started operation: 1 for erase, 0 for program |
| op_addr | input | AW | Target address of the started operation |
| op_wdata | input | DW | Data being programmed |
| op_done | input | 1 | Engine reports the running operation complete |
| susp_req | input | 1 | Suspend the running erase |
| resume_req | input | 1 | Resume the suspended erase |
| rd_stb | input | 1 | Read strobe |
| rd_addr | input | AW | Read address |
| arr_data | input | DW | Array word at `rd_addr` |
| rd_data | output | DW | Registered read result |
| busy_n | output | 1 | Low while an operation is running |

## Verification
Two pairs of events can fall in the same cycle: a status read with the completion pulse, and an IDLE read with a start pulse. The bench drives `rd_stb` and `op_done` on the same edge and expects the status word, with bit 7 still complemented, followed by `busy_n` high and array data on the next read. It likewise drives `rd_stb` together with `op_start` and expects plain array data with the toggle bits still cleared on the first status read. Sweeps over all eight address slices, for a small-bank and a large-bank operation, compare every word against values the bench derives from the slice index.

// File: rtl/wsg_pkg.sv
package wsg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PROG  = 2'd1,
        ST_ERASE = 2'd2,
        ST_SUSP  = 2'd3
    } wsg_state_e;

    localparam int POLL_BIT  = 7;
    localparam int TOG_BIT   = 6;
    localparam int ETOG_BIT  = 2;
    localparam int SLICE_W   = 3;

endpackage

// File: rtl/wsg_bank_dec.sv
module wsg_bank_dec #(
    parameter int AW           = 21,
    parameter int SMALL_SLICES = 1,
    parameter bit SMALL_AT_TOP = 1'b0
) (
    input  logic [AW-1:0] addr,
    output logic          is_large
);
    import wsg_pkg::*;

    localparam int TOP_EDGE = (1 << SLICE_W) - SMALL_SLICES;

    logic [SLICE_W-1:0] slice;
    logic [AW-SLICE_W-1:0] unused_low;

    assign slice      = addr[AW-1 -: SLICE_W];
    assign unused_low = addr[AW-SLICE_W-1:0];

    generate
        if (SMALL_AT_TOP) begin : g_small_top
            assign is_large = (slice < SLICE_W'(TOP_EDGE));
        end else begin : g_small_bottom
            assign is_large = (slice >= SLICE_W'(SMALL_SLICES));
        end
    endgenerate

endmodule

// File: rtl/wsg_toggle.sv
module wsg_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic flip,
    output logic q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else if (clr) begin
            q <= 1'b0;
        end else if (flip) begin
            q <= ~q;
        end
    end
endmodule

// File: rtl/wsg_seq.sv
module wsg_seq #(
    parameter int SECT_W = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 op_start,
    input  logic                 op_erase,
    input  logic                 op_large,
    input  logic [SECT_W-1:0]    op_sect,
    input  logic                 op_poll,
    input  logic                 op_done,
    input  logic                 susp_req,
    input  logic                 resume_req,
    output wsg_pkg::wsg_state_e  state,
    output logic                 busy_large,
    output logic [SECT_W-1:0]    busy_sect,
    output logic                 poll_bit,
    output logic                 busy_n
);
    import wsg_pkg::*;

    wsg_state_e nxt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // transitions: START_PROG, START_ERASE, FINISH, SUSPEND, RESUME
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (op_start) nxt = op_erase ? ST_ERASE : ST_PROG;
            ST_PROG:  if (op_done) nxt = ST_IDLE;
            ST_ERASE: begin
                if (op_done)       nxt = ST_IDLE;
                else if (susp_req) nxt = ST_SUSP;
            end
            ST_SUSP:  if (resume_req) nxt = ST_ERASE;
        endcase
    end

    // operation context, captured only when a start is accepted
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_large <= 1'b0;
            busy_sect  <= '0;
            poll_bit   <= 1'b0;
        end else if (state == ST_IDLE && op_start) begin
            busy_large <= op_large;
            busy_sect  <= op_sect;
            poll_bit   <= op_poll;
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            ST_PROG, ST_ERASE: busy_n = 1'b0;
            default:           busy_n = 1'b1;
        endcase
    end

endmodule

// File: rtl/wsg_status_mux.sv
module wsg_status_mux #(
    parameter int DW = 16
) (
    input  wsg_pkg::wsg_state_e state,
    input  logic                rd_stb,
    input  logic                bank_hit,
    input  logic                sect_hit,
    input  logic                tog_main,
    input  logic                tog_erase,
    input  logic                poll_bit,
    input  logic [DW-1:0]       arr_data,
    output logic [DW-1:0]       word,
    output logic                flip_main,
    output logic                flip_erase
);
    import wsg_pkg::*;

    always_comb begin
        word       = arr_data;
        flip_main  = 1'b0;
        flip_erase = 1'b0;
        unique case (state)
            ST_IDLE: begin
            end
            ST_PROG: if (bank_hit) begin
                word[POLL_BIT] = ~poll_bit;
                word[TOG_BIT]  = tog_main;
                flip_main      = rd_stb;
            end
            ST_ERASE: if (bank_hit) begin
                word[POLL_BIT] = 1'b0;
                word[TOG_BIT]  = tog_main;
                word[ETOG_BIT] = tog_erase;
                flip_main      = rd_stb;
                flip_erase     = rd_stb;
            end
            ST_SUSP: if (sect_hit) begin
                word[POLL_BIT] = 1'b1;
                word[TOG_BIT]  = 1'b1;
                word[ETOG_BIT] = tog_erase;
                flip_erase     = rd_stb;
            end
        endcase
    end
endmodule

// File: rtl/flash_wstat.sv
module flash_wstat #(
    parameter int AW           = 21,
    parameter int DW           = 16,
    parameter int SECT_W       = 10,
    parameter int SMALL_SLICES = 1,
    parameter bit SMALL_AT_TOP = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_start,
    input  logic          op_erase,
    input  logic [AW-1:0] op_addr,
    input  logic [DW-1:0] op_wdata,
    input  logic          op_done,
    input  logic          susp_req,
    input  logic          resume_req,
    input  logic          rd_stb,
    input  logic [AW-1:0] rd_addr,
    input  logic [DW-1:0] arr_data,
    output logic [DW-1:0] rd_data,
    output logic          busy_n
);
    import wsg_pkg::*;

    wsg_state_e        st;
    logic              rd_large, op_large, busy_large;
    logic [SECT_W-1:0] busy_sect;
    logic              poll_bit;
    logic              bank_hit, sect_hit;
    logic              tog_main, tog_erase, flip_main, flip_erase, tog_clr;
    logic [DW-1:0]     word;
    logic              unused_bits;

    assign unused_bits = ^{op_wdata[DW-1:POLL_BIT+1], op_wdata[POLL_BIT-1:0]};

    wsg_bank_dec #(.AW(AW), .SMALL_SLICES(SMALL_SLICES), .SMALL_AT_TOP(SMALL_AT_TOP))
        u_rd_dec (.addr(rd_addr), .is_large(rd_large));
    wsg_bank_dec #(.AW(AW), .SMALL_SLICES(SMALL_SLICES), .SMALL_AT_TOP(SMALL_AT_TOP))
        u_op_dec (.addr(op_addr), .is_large(op_large));

    wsg_seq #(.SECT_W(SECT_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .op_start(op_start), .op_erase(op_erase), .op_large(op_large),
        .op_sect(op_addr[AW-1 -: SECT_W]), .op_poll(op_wdata[POLL_BIT]),
        .op_done(op_done), .susp_req(susp_req), .resume_req(resume_req),
        .state(st), .busy_large(busy_large), .busy_sect(busy_sect),
        .poll_bit(poll_bit), .busy_n(busy_n)
    );

    assign bank_hit = (rd_large == busy_large);
    assign sect_hit = bank_hit && (rd_addr[AW-1 -: SECT_W] == busy_sect);
    assign tog_clr  = op_start && (st == ST_IDLE);

    wsg_toggle u_tog_main  (.clk(clk), .rst_n(rst_n), .clr(tog_clr), .flip(flip_main),  .q(tog_main));
    wsg_toggle u_tog_erase (.clk(clk), .rst_n(rst_n), .clr(tog_clr), .flip(flip_erase), .q(tog_erase));

    wsg_status_mux #(.DW(DW)) u_mux (
        .state(st), .rd_stb(rd_stb), .bank_hit(bank_hit), .sect_hit(sect_hit),
        .tog_main(tog_main), .tog_erase(tog_erase), .poll_bit(poll_bit),
        .arr_data(arr_data), .word(word),
        .flip_main(flip_main), .flip_erase(flip_erase)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rd_data <= '0;
        else if (rd_stb) rd_data <= word;
    end

endmodule

// File: rtl/wsg_checks.sv
module wsg_checks #(
    parameter int DW = 16
) (
    input logic                clk,
    input logic                rst_n,
    input wsg_pkg::wsg_state_e st,
    input logic                op_start,
    input logic                op_done,
    input logic                rd_stb,
    input logic                bank_hit,
    input logic                sect_hit,
    input logic                poll_bit,
    input logic                tog_main,
    input logic [DW-1:0]       arr_data,
    input logic [DW-1:0]       rd_data,
    input logic                busy_n
);
    import wsg_pkg::*;

    a_r2_idle_array: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && st == ST_IDLE) |=> rd_data == $past(arr_data));

    a_r3_prog_poll: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && st == ST_PROG && bank_hit) |=> rd_data[POLL_BIT] == !$past(poll_bit));

    a_r4_erase_poll: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && st == ST_ERASE && bank_hit) |=> rd_data[POLL_BIT] == 1'b0);

    a_r5_main_flips: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !op_start && (st == ST_PROG || st == ST_ERASE) && bank_hit)
        |=> tog_main != $past(tog_main));

    a_r6_other_bank: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && st != ST_IDLE && !bank_hit) |=> rd_data == $past(arr_data));

    a_r7_susp_sector: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && st == ST_SUSP && sect_hit) |=> rd_data[POLL_BIT:TOG_BIT] == 2'b11);

    a_r8_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && op_start) |=> !busy_n);

    a_r8_susp_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SUSP) |-> busy_n);

    a_r9_finish_ready: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_PROG || st == ST_ERASE) && op_done) |=> busy_n);

    a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(rd_data));

endmodule

bind flash_wstat wsg_checks #(.DW(DW)) u_wsg_checks (
    .clk(clk), .rst_n(rst_n), .st(st), .op_start(op_start), .op_done(op_done),
    .rd_stb(rd_stb), .bank_hit(bank_hit), .sect_hit(sect_hit), .poll_bit(poll_bit),
    .tog_main(tog_main), .arr_data(arr_data), .rd_data(rd_data), .busy_n(busy_n)
);

// File: tb/flash_wstat_test.sv
`timescale 1ns/1ps
module flash_wstat_test;
    localparam int AW = 9;
    localparam int DW = 16;
    localparam int SW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          op_start = 1'b0, op_erase = 1'b0, op_done = 1'b0;
    logic          susp_req = 1'b0, resume_req = 1'b0, rd_stb = 1'b0;
    logic [AW-1:0] op_addr = '0, rd_addr = '0;
    logic [DW-1:0] op_wdata = '0, arr_data, rd_data;
    logic          busy_n;

    int n_tests = 0, n_fail = 0;
    bit finished = 1'b0;

    // bench model: 0 idle, 1 program, 2 erase, 3 suspended
    int         m_mode = 0;
    logic       m_large = 1'b0, m_w7 = 1'b0, t6 = 1'b0, t2 = 1'b0;
    logic [SW-1:0] m_sect = '0;

    always #2 clk = ~clk;

    flash_wstat #(.AW(AW), .DW(DW), .SECT_W(SW), .SMALL_SLICES(1), .SMALL_AT_TOP(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_erase(op_erase),
        .op_addr(op_addr), .op_wdata(op_wdata), .op_done(op_done),
        .susp_req(susp_req), .resume_req(resume_req), .rd_stb(rd_stb),
        .rd_addr(rd_addr), .arr_data(arr_data), .rd_data(rd_data), .busy_n(busy_n)
    );

    function automatic logic [DW-1:0] arr_of(input logic [AW-1:0] a);
        return {a[7:0] ^ 8'hA5, a[7:0] + 8'h11};
    endfunction

    assign arr_data = arr_of(rd_addr);

    // R10: slice 0 is the small bank, slices 1..7 the large one
    function automatic logic large_of(input logic [AW-1:0] a);
        return a[AW-1 -: 3] != 3'd0;
    endfunction

    task automatic check(input bit ok, input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    function automatic logic [DW-1:0] expect_word(input logic [AW-1:0] a);
        logic [DW-1:0] w;
        logic hit, shit;
        w    = arr_of(a);
        hit  = (large_of(a) == m_large);
        shit = hit && (a[AW-1 -: SW] == m_sect);
        if (m_mode == 1 && hit) begin
            w[7] = ~m_w7; w[6] = t6;
        end else if (m_mode == 2 && hit) begin
            w[7] = 1'b0; w[6] = t6; w[2] = t2;
        end else if (m_mode == 3 && shit) begin
            w[7] = 1'b1; w[6] = 1'b1; w[2] = t2;
        end
        return w;
    endfunction

    task automatic model_read(input logic [AW-1:0] a);
        logic hit, shit;
        hit  = (large_of(a) == m_large);
        shit = hit && (a[AW-1 -: SW] == m_sect);
        if ((m_mode == 1 || m_mode == 2) && hit) t6 = ~t6;
        if ((m_mode == 2 && hit) || (m_mode == 3 && shit)) t2 = ~t2;
    endtask

    task automatic rd(input logic [AW-1:0] a, input string req);
        logic [DW-1:0] e;
        @(negedge clk);
        e = expect_word(a);
        model_read(a);
        rd_stb = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_stb = 1'b0;
        check(rd_data === e, req, rd_data, e);
    endtask

    task automatic start(input logic er, input logic [AW-1:0] a, input logic [DW-1:0] wd);
        @(negedge clk);
        op_start = 1'b1; op_erase = er; op_addr = a; op_wdata = wd;
        @(negedge clk);
        op_start = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk); op_done = 1'b1;
        @(negedge clk); op_done = 1'b0;
    endtask

    task automatic pulse_susp();
        @(negedge clk); susp_req = 1'b1;
        @(negedge clk); susp_req = 1'b0;
    endtask

    task automatic pulse_resume();
        @(negedge clk); resume_req = 1'b1;
        @(negedge clk); resume_req = 1'b0;
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] held, e;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(rd_data === '0, "R1 rd_data", rd_data, '0);
        check(busy_n === 1'b1, "R1 busy_n", {15'b0, busy_n}, 16'h1);
        rst_n = 1'b1;

        // R2: idle reads over every slice
        for (int s = 0; s < 8; s++) rd(AW'((s << 6) | (s * 5)), "R2 idle read");

        // R12: data holds without a strobe while address and array data move
        held = rd_data;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); rd_addr = AW'(k * 37 + 3);
        end
        @(negedge clk);
        check(rd_data === held, "R12 hold", rd_data, held);

        // R11: suspend and resume in IDLE are ignored
        pulse_susp(); pulse_resume();
        check(busy_n === 1'b1, "R11 idle suspend busy_n", {15'b0, busy_n}, 16'h1);
        rd(9'h045, "R11 idle read after suspend");

        // program in the small bank (slice 0), data bit 7 = 1
        start(1'b0, 9'h010, 16'h1280);
        m_mode = 1; m_large = 1'b0; m_w7 = 1'b1; m_sect = 6'h02; t6 = 0; t2 = 0;
        check(busy_n === 1'b0, "R8 program busy", {15'b0, busy_n}, 16'h0);
        for (int pass = 0; pass < 2; pass++)
            for (int s = 0; s < 8; s++) rd(AW'((s << 6) | 6'h0B), "R3 R6 R10 program sweep");
        repeat (5) @(negedge clk);
        rd(9'h001, "R5 no flip on idle clocks");
        // R11: a start while programming is ignored
        start(1'b1, 9'h1C0, 16'h0000);
        rd(9'h003, "R11 start ignored in program");
        check(busy_n === 1'b0, "R11 still busy", {15'b0, busy_n}, 16'h0);
        pulse_resume();
        rd(9'h004, "R11 resume ignored in program");
        // R9: read in the same cycle as completion returns status
        @(negedge clk);
        e = expect_word(9'h005);
        rd_stb = 1'b1; rd_addr = 9'h005; op_done = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0; op_done = 1'b0;
        check(rd_data === e, "R9 read with done", rd_data, e);
        m_mode = 0;
        check(busy_n === 1'b1, "R9 ready after finish", {15'b0, busy_n}, 16'h1);
        rd(9'h005, "R9 array after finish");

        // R2/R5: read coinciding with the start sees IDLE; toggles start at 0
        @(negedge clk);
        e = arr_of(9'h0D3);
        rd_stb = 1'b1; rd_addr = 9'h0D3;
        op_start = 1'b1; op_erase = 1'b1; op_addr = 9'h0D0; op_wdata = 16'h0;
        @(negedge clk);
        rd_stb = 1'b0; op_start = 1'b0;
        check(rd_data === e, "R2 read with start", rd_data, e);
        m_mode = 2; m_large = 1'b1; m_sect = 6'h1A; t6 = 0; t2 = 0;
        check(busy_n === 1'b0, "R8 erase busy", {15'b0, busy_n}, 16'h0);
        for (int s = 0; s < 8; s++) rd(AW'((s << 6) | 6'h21), "R4 R5 R10 erase sweep");
        rd(9'h0D1, "R4 erase target");

        // R7: suspend
        pulse_susp();
        m_mode = 3;
        check(busy_n === 1'b1, "R8 suspend ready", {15'b0, busy_n}, 16'h1);
        rd(9'h0D5, "R7 suspended sector");
        rd(9'h0E0, "R7 other sector same bank");
        rd(9'h0D7, "R7 suspended sector again");
        rd(9'h010, "R7 small bank in suspend");
        // R11: start while suspended is ignored
        start(1'b0, 9'h020, 16'hFFFF);
        check(busy_n === 1'b1, "R11 start ignored in suspend", {15'b0, busy_n}, 16'h1);
        rd(9'h0D2, "R7 sector after ignored start");

        // R8: resume
        pulse_resume();
        m_mode = 2;
        check(busy_n === 1'b0, "R8 resume busy", {15'b0, busy_n}, 16'h0);
        rd(9'h1F0, "R4 after resume");
        rd(9'h040, "R4 after resume second");
        rd(9'h002, "R6 small bank during erase");

        pulse_done();
        m_mode = 0;
        check(busy_n === 1'b1, "R9 erase finished", {15'b0, busy_n}, 16'h1);
        for (int s = 0; s < 8; s++) rd(AW'((s << 6) | 6'h1A), "R9 array after erase");

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule